// File: doc/BRIEF.md
# Bidirectional Twisted-Ring Prescaler

This block is a reversible twisted-ring (Johnson) counter. Its job is to sit under a wide, slow counter segment and tell that segment when to step. The ring has `RING_W` flip-flops and walks through `2*RING_W` states. That makes it equivalent to a binary counter of `$clog2(2*RING_W)` bits, and those bits sit directly below the wide segment. When the ring steps forward it shifts toward its top end, and the inverted top bit enters at the bottom. When it steps backward it shifts toward its bottom end, and the inverted bottom bit enters at the top. Neither direction has a carry chain, so the cycle time does not depend on the width of the segment above.

The upper segment needs two wrap indications. The carry strobe tells it to increment; the borrow strobe tells it to decrement or to reverse. Each strobe is decoded from two adjacent ring bits and gated by the enable and the direction, so it is valid in the same cycle the ring leaves its wrap state. The direction input may change on any cycle, including the cycle right after a wrap, and both the ring and the strobes stay consistent with a reference binary up/down counter.

The block also exposes a decoded binary copy of the count for observation. The reset input is asynchronous and active low. Its release is synchronised inside the block, so counting starts on the third rising clock edge after `rst_n` goes high.

Top module: `jc_prescaler`

## Requirements
- R1: While reset is applied, the ring is all zeros, the binary value is 0, and both strobes are low when the enable is low.
- R2: With the enable high and the direction low (up), each rising edge moves the binary value from v to (v+1) mod 2*RING_W. Ring bit i becomes ring bit i-1, and bit 0 takes the inverse of the top bit.
- R3: With the enable high and the direction high (down), each rising edge moves the binary value from v to (v-1) mod 2*RING_W. Ring bit i becomes ring bit i+1, and the top bit takes the inverse of bit 0.
- R4: With the enable low, the ring and the binary value hold at every edge, whatever the direction input is.
- R5: The binary output equals the number of ones in the ring when the top bit is 0, and equals 2*RING_W minus that number when the top bit is 1. For RING_W=8, value v in 0..8 is the ring with its low v bits set, and value v in 9..15 is all ones shifted left by v-8.
- R6: The carry strobe is high exactly when the enable is high, the direction is up and the value is 2*RING_W-1 (ring pattern: top bit 1, next bit 0).
- R7: The borrow strobe is high exactly when the enable is high, the direction is down and the value is 0 (ring pattern: top bit 0, bit 0 is 0).
- R8: A direction reversal on any cycle, including at the wrap values, takes effect at the very next edge, with no lost or extra step.
- R9: The ring only ever holds one of the 2*RING_W valid twisted-ring patterns, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count enable from the lower stages |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| ring_q | output | RING_W | Twisted-ring state |
| bin_val | output | $clog2(2*RING_W) | Binary equivalent of the ring state |
| carry_o | output | 1 | Single-cycle up-wrap strobe |
| borrow_o | output | 1 | Single-cycle down-wrap strobe |

## Verification
A wrong ring bit shows up at `ring_q` one cycle after the faulty edge. It also shifts `bin_val` away from the reference count, because every state has a distinct pattern. A bad wrap decode shows up as a strobe that is missing, misplaced or doubled. At most 2*RING_W enabled steps are needed to reach both wrap points in either direction. The bench therefore steps the ring across both wrap points, reverses direction right at them, and runs a long pseudo-random mix of enable and direction. At every cycle it compares all four outputs with an arithmetic reference counter.

// File: rtl/jc_pkg.sv
package jc_pkg;
  // direction encoding on the dir_dn input
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } jc_dir_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BWD  = 2'd2
  } jc_step_e;
endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/jc_ring_core.sv
module jc_ring_core
  import jc_pkg::*;
#(
  parameter int RING_W = 8
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              cnt_en,
  input  logic              dir_dn,
  output logic [RING_W-1:0] ring_q
);
  jc_step_e          step;
  logic [RING_W-1:0] fwd_d;
  logic [RING_W-1:0] bwd_d;
  logic [RING_W-1:0] ring_d;

  always_comb begin
    if (!cnt_en) begin
      step = STEP_HOLD;
    end else if (jc_dir_e'(dir_dn) == DIR_DOWN) begin
      step = STEP_BWD;
    end else begin
      step = STEP_FWD;
    end
  end

  // each bit takes its neighbour; the end bits take the inverted far end
  for (genvar i = 0; i < RING_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign fwd_d[i] = ~ring_q[RING_W-1];
    end else begin : g_lo_n
      assign fwd_d[i] = ring_q[i-1];
    end
    if (i == RING_W-1) begin : g_hi
      assign bwd_d[i] = ~ring_q[0];
    end else begin : g_hi_n
      assign bwd_d[i] = ring_q[i+1];
    end
  end

  always_comb begin
    unique case (step)
      STEP_FWD: ring_d = fwd_d;
      STEP_BWD: ring_d = bwd_d;
      default:  ring_d = ring_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ring_q <= '0;
    end else if (cnt_en) begin
      ring_q <= ring_d;
    end
  end
endmodule

// File: rtl/jc_bin_decode.sv
module jc_bin_decode #(
  parameter int RING_W = 8,
  localparam int BIN_W = $clog2(2*RING_W),
  localparam int CNT_W = BIN_W + 1
) (
  input  logic [RING_W-1:0] ring_q,
  output logic [BIN_W-1:0]  bin_val
);
  localparam logic [CNT_W-1:0] STATES = CNT_W'(2*RING_W);

  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] full;

  always_comb begin
    ones = '0;
    for (int i = 0; i < RING_W; i++) begin
      ones = ones + CNT_W'(ring_q[i]);
    end
  end

  always_comb begin
    if (ring_q[RING_W-1]) begin
      full = STATES - ones;
    end else begin
      full = ones;
    end
    bin_val = full[BIN_W-1:0];
  end
endmodule

// File: rtl/jc_wrap_detect.sv
module jc_wrap_detect
  import jc_pkg::*;
#(
  parameter int RING_W = 8
) (
  input  logic [RING_W-1:0] ring_q,
  input  logic              cnt_en,
  input  logic              dir_dn,
  output logic              carry_o,
  output logic              borrow_o
);
  logic at_top;
  logic at_zero;
  logic going_up;

  // two-bit decodes: each pattern is unique among the valid states
  assign at_top   = ring_q[RING_W-1] & ~ring_q[RING_W-2];
  assign at_zero  = ~ring_q[RING_W-1] & ~ring_q[0];
  assign going_up = (jc_dir_e'(dir_dn) == DIR_UP);

  always_comb begin
    carry_o  = cnt_en &  going_up & at_top;
    borrow_o = cnt_en & ~going_up & at_zero;
  end
endmodule

// File: rtl/jc_prescaler.sv
module jc_prescaler #(
  parameter int RING_W = 8,
  localparam int BIN_W = $clog2(2*RING_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              dir_dn,
  output logic [RING_W-1:0] ring_q,
  output logic [BIN_W-1:0]  bin_val,
  output logic              carry_o,
  output logic              borrow_o
);
  logic rst_sync_n;

  jc_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  jc_ring_core #(.RING_W(RING_W)) core_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cnt_en     (cnt_en),
    .dir_dn     (dir_dn),
    .ring_q     (ring_q)
  );

  jc_bin_decode #(.RING_W(RING_W)) dec_i (
    .ring_q  (ring_q),
    .bin_val (bin_val)
  );

  jc_wrap_detect #(.RING_W(RING_W)) wrap_i (
    .ring_q   (ring_q),
    .cnt_en   (cnt_en),
    .dir_dn   (dir_dn),
    .carry_o  (carry_o),
    .borrow_o (borrow_o)
  );
endmodule

// File: rtl/jc_prescaler_chk.sv
module jc_prescaler_chk #(
  parameter int RING_W = 8,
  localparam int BIN_W = $clog2(2*RING_W)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cnt_en,
  input logic              dir_dn,
  input logic [RING_W-1:0] ring_q,
  input logic [BIN_W-1:0]  bin_val,
  input logic              carry_o,
  input logic              borrow_o
);
  localparam logic [BIN_W-1:0] ONE = BIN_W'(1);
  localparam logic [BIN_W-1:0] TOP = BIN_W'(2*RING_W-1);

  logic [RING_W-1:0] twist;
  assign twist = ring_q ^ {ring_q[RING_W-2:0], ~ring_q[RING_W-1]};

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_en && !dir_dn) |=> (bin_val == BIN_W'($past(bin_val) + ONE)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_en && dir_dn) |=> (bin_val == BIN_W'($past(bin_val) - ONE)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_en |=> $stable(ring_q));

  // R6
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry_o |=> (bin_val == '0));

  // R7
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    borrow_o |=> (bin_val == TOP));

  // R9
  valid_ring_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(twist) == 1);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(carry_o && borrow_o));
endmodule

bind jc_prescaler jc_prescaler_chk #(.RING_W(RING_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cnt_en     (cnt_en),
  .dir_dn     (dir_dn),
  .ring_q     (ring_q),
  .bin_val    (bin_val),
  .carry_o    (carry_o),
  .borrow_o   (borrow_o)
);

// File: tb/jc_prescaler_tb.sv
`timescale 1ns/1ps
module jc_prescaler_tb_top;
  localparam int RING_W = 8;
  localparam int BIN_W  = 4;
  localparam int MODN   = 16;

  logic              clk;
  logic              rst_n;
  logic              cnt_en;
  logic              dir_dn;
  logic [RING_W-1:0] ring_q;
  logic [BIN_W-1:0]  bin_val;
  logic              carry_o;
  logic              borrow_o;

  int n_chk  = 0;
  int n_fail = 0;
  int ref_v  = 0;
  string last_tag = "R1";

  jc_prescaler #(.RING_W(RING_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .dir_dn   (dir_dn),
    .ring_q   (ring_q),
    .bin_val  (bin_val),
    .carry_o  (carry_o),
    .borrow_o (borrow_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] ring_of(int v);
    if (v <= 8) return 8'((9'd1 << v) - 9'd1);
    else        return 8'(8'hFF << (v - 8));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // check outputs against the reference count, then advance it
  task automatic step(input logic e, input logic d);
    logic c_exp;
    logic b_exp;
    @(negedge clk);
    cnt_en = e;
    dir_dn = d;
    #1;
    chk(bin_val == BIN_W'(ref_v), {"R5 bin after ", last_tag}, int'(bin_val), ref_v);
    chk(ring_q == ring_of(ref_v), {"R9 ring after ", last_tag}, int'(ring_q), int'(ring_of(ref_v)));
    c_exp = e && !d && (ref_v == MODN-1);
    b_exp = e &&  d && (ref_v == 0);
    chk(carry_o == c_exp, "R6 carry", int'(carry_o), int'(c_exp));
    chk(borrow_o == b_exp, "R7 borrow", int'(borrow_o), int'(b_exp));
    if (!e)      last_tag = "R4 hold";
    else if (d)  last_tag = "R3 down";
    else         last_tag = "R2 up";
    if (e) begin
      ref_v = d ? (ref_v + MODN - 1) % MODN : (ref_v + 1) % MODN;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cnt_en = 1'b0;
    dir_dn = 1'b0;
    rst_n  = 1'b0;
    #1;
    ref_v = 0;
    chk(ring_q == '0, "R1 ring", int'(ring_q), 0);
    chk(bin_val == '0, "R1 bin", int'(bin_val), 0);
    chk(!carry_o && !borrow_o, "R1 strobes", int'({carry_o, borrow_o}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    last_tag = "R1";
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    dir_dn = 1'b0;
    do_reset();

    // R4: enable low, both directions
    for (int i = 0; i < 6; i++) step(1'b0, 1'(i % 2));

    // R2: full up sweep past the wrap
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);

    // R3: full down sweep through zero twice
    for (int i = 0; i < 36; i++) step(1'b1, 1'b1);

    // R8: reversal each cycle around the top wrap
    while (ref_v != MODN-1) step(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'(i % 2));
      last_tag = "R8 reversal";
    end

    // R8: reversal each cycle around zero
    while (ref_v != 0) step(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'(~i[0]));
      last_tag = "R8 reversal";
    end

    // mixed pseudo-random enable and direction
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[5]);
    end

    // R1: reset in mid count
    while (ref_v != 11) step(1'b1, 1'b0);
    do_reset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);

    finish_run();
  end
endmodule